// File: doc/BRIEF.md
# Vector Null-Terminated String Isolator

The block takes a 128-bit vector holding sixteen byte elements or eight halfword elements and treats it as a short zero-terminated string. Walking the elements in a chosen scan direction, it copies each element unchanged into the same position of the result until it meets the first element whose bits are all zero. That element and every element after it in scan order come out as zero. One flag reports whether a terminator was found at all. A second flag tests bit 0 of all sixteen bytes, either for all ones or for all zeros.

Each operation carries its own controls: the element width, the scan direction and the bit-0 test mode. A datapath presents one vector per cycle with `in_valid`. The result and both flags are registered and appear on the next cycle together with a one-cycle `out_valid` pulse. A two-state machine tracks the output: `ST_IDLE` when no result is presented, and `ST_EMIT` in the cycle after an accepted input. The transition `ST_IDLE -> ST_EMIT` and the self-loop `ST_EMIT -> ST_EMIT` are taken whenever `in_valid` is high. The transitions `ST_EMIT -> ST_IDLE` and `ST_IDLE -> ST_IDLE` are taken whenever it is low.

Top module: `strio_isolator`

## Requirements
- R1: After reset `out_valid`, `out_vec`, `any_zero` and `lsb_test` are all 0, and the state is `ST_IDLE`.
- R2: Each input accepted with `in_valid` = 1 produces `out_valid` = 1 in the following cycle only. With `in_valid` = 0, `out_valid` is 0 in the following cycle. Back-to-back inputs give back-to-back results.
- R3: With `scan_rev` = 0, scanning starts at the most significant element (bits [VEC_W-1 -: element width]) and moves down. Elements above the first zero element are copied, and the zero element and all lower elements are output as zero.
- R4: With `scan_rev` = 1, scanning starts at the least significant element (bits [element width-1:0]) and moves up. Elements below the first zero element are copied, and the zero element and all higher elements are output as zero.
- R5: `elem_half` = 0 selects byte elements (16 lanes). `elem_half` = 1 selects halfword elements (8 lanes of 16 bits). An element counts as a terminator only if all of its bits are zero.
- R6: An input with no zero element of the selected width is passed through unchanged, with `any_zero` = 0.
- R7: `any_zero` is 1 exactly when the input holds at least one zero element of the selected width.
- R8: With `lsb_mode` = 1, `lsb_test` is 1 exactly when bit 0 of every byte (bits 0, 8, ..., 120) is 1. With `lsb_mode` = 0, it is 1 exactly when all those bits are 0. It does not depend on `elem_half` or `scan_rev`.
- R9: A terminator in the first scanned element makes the whole result zero. A terminator only in the last scanned element leaves the result equal to the input.
- R10: The result never sets a bit that is clear in the input, and while `out_valid` is 0 the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector and controls are valid this cycle |
| in_vec | input | VEC_W | Input vector |
| elem_half | input | 1 | 0: byte elements, 1: halfword elements |
| scan_rev | input | 1 | 0: scan from most significant element, 1: from least significant |
| lsb_mode | input | 1 | 1: test bit 0 of every byte for all ones, 0: for all zeros |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_vec | output | VEC_W | Isolated string result |
| any_zero | output | 1 | Input held at least one zero element |
| lsb_test | output | 1 | Result of the bit-0 test over all bytes |

## Verification
The bench builds the block with its default parameters: a 128-bit vector and 8-bit base elements. These bring into reach both lane counts, sixteen bytes and eight halfwords, and the case where a zero byte that is half of a nonzero halfword counts as a terminator in one width and not in the other. The terminator is placed at the first, a middle and the last scan position in both directions. Back-to-back operations that flip direction and width every cycle show that no state leaks from one operation to the next.

// File: rtl/strio_pkg.sv
package strio_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } strio_state_e;

    typedef enum logic {
        SCAN_FROM_TOP = 1'b0,
        SCAN_FROM_BOT = 1'b1
    } strio_dir_e;

    localparam int unsigned STRIO_WIDTHS = 2;
endpackage

// File: rtl/strio_scan.sv
module strio_scan #(
    parameter int unsigned VEC_W = 128,
    parameter int unsigned EW    = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic             rev_i,
    output logic [VEC_W-1:0] res_o,
    output logic             found_o
);
    localparam int unsigned N = VEC_W / EW;

    logic [N-1:0] is_zero;

    generate
        for (genvar e = 0; e < N; e++) begin : g_zero
            assign is_zero[e] = (vec_i[e*EW +: EW] == '0);
        end
    endgenerate

    always_comb begin
        logic seen;
        int   idx;
        seen  = 1'b0;
        res_o = '0;
        for (int s = 0; s < N; s++) begin
            idx = rev_i ? s : (N - 1 - s);
            if (is_zero[idx]) begin
                seen = 1'b1;
            end
            res_o[idx*EW +: EW] = seen ? '0 : vec_i[idx*EW +: EW];
        end
        found_o = seen;
    end
endmodule

// File: rtl/strio_lsb.sv
module strio_lsb #(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ones_mode_i,
    output logic             test_o
);
    localparam int unsigned NB = VEC_W / BYTE_W;

    logic [NB-1:0] low_bits;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_low
            assign low_bits[b] = vec_i[b*BYTE_W];
        end
    endgenerate

    assign test_o = ones_mode_i ? (&low_bits) : ~(|low_bits);
endmodule

// File: rtl/strio_isolator.sv
module strio_isolator
    import strio_pkg::*;
#(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             elem_half,
    input  logic             scan_rev,
    input  logic             lsb_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             any_zero,
    output logic             lsb_test
);
    strio_state_e state_q, state_d;

    logic [VEC_W-1:0] scan_res [STRIO_WIDTHS];
    logic             scan_hit [STRIO_WIDTHS];
    logic             lsb_comb;
    logic [VEC_W-1:0] res_sel;
    logic             hit_sel;

    generate
        for (genvar w = 0; w < STRIO_WIDTHS; w++) begin : g_width
            strio_scan #(
                .VEC_W(VEC_W),
                .EW   (BYTE_W << w)
            ) u_scan (
                .vec_i  (in_vec),
                .rev_i  (scan_rev),
                .res_o  (scan_res[w]),
                .found_o(scan_hit[w])
            );
        end
    endgenerate

    strio_lsb #(
        .VEC_W (VEC_W),
        .BYTE_W(BYTE_W)
    ) u_lsb (
        .vec_i      (in_vec),
        .ones_mode_i(lsb_mode),
        .test_o     (lsb_comb)
    );

    assign res_sel = elem_half ? scan_res[1] : scan_res[0];
    assign hit_sel = elem_half ? scan_hit[1] : scan_hit[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec  <= '0;
            any_zero <= 1'b0;
            lsb_test <= 1'b0;
        end else if (in_valid) begin
            out_vec  <= res_sel;
            any_zero <= hit_sel;
            lsb_test <= lsb_comb;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/strio_isolator_chk.sv
module strio_isolator_chk #(
    parameter int unsigned VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] in_vec,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec,
    input logic             any_zero
);
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !any_zero) |-> (out_vec == $past(in_vec)));

    p_no_new_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_vec & ~$past(in_vec)) == '0));

    p_all_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(in_vec) == '0)) |-> (any_zero && (out_vec == '0)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(out_vec));
endmodule

bind strio_isolator strio_isolator_chk #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_vec   (in_vec),
    .out_valid(out_valid),
    .out_vec  (out_vec),
    .any_zero (any_zero)
);

// File: tb/strio_isolator_tb.sv
module strio_isolator_tb_top;
    localparam int unsigned VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          elem_half = 1'b0;
    logic          scan_rev = 1'b0;
    logic          lsb_mode = 1'b0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          any_zero;
    logic          lsb_test;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strio_isolator #(.VEC_W(VW), .BYTE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .elem_half(elem_half), .scan_rev(scan_rev), .lsb_mode(lsb_mode),
        .out_valid(out_valid), .out_vec(out_vec), .any_zero(any_zero),
        .lsb_test(lsb_test)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected result: locate the first terminator in scan order, then clear
    // from that scan position onward.
    task automatic expect_of(input logic [VW-1:0] v, input bit half, input bit rev,
                             input bit ones, output logic [VW-1:0] r,
                             output bit hit, output bit lt);
        int ew = half ? 16 : 8;
        int n  = VW / ew;
        int first = n;
        int ones_cnt = 0;
        for (int p = n - 1; p >= 0; p--) begin
            int e = rev ? p : (n - 1 - p);
            if (((v >> (e * ew)) & ((1 << ew) - 1)) == 0) first = p;
        end
        hit = (first < n);
        r = v;
        for (int p = first; p < n; p++) begin
            int e = rev ? p : (n - 1 - p);
            for (int b = 0; b < ew; b++) r[e*ew + b] = 1'b0;
        end
        for (int b = 0; b < VW / 8; b++) if (v[b*8]) ones_cnt++;
        lt = ones ? (ones_cnt == VW / 8) : (ones_cnt == 0);
    endtask

    task automatic apply(input string req, input logic [VW-1:0] v,
                         input bit half, input bit rev, input bit ones);
        logic [VW-1:0] er;
        bit eh, el;
        expect_of(v, half, rev, ones, er, eh, el);
        @(negedge clk);
        in_valid = 1'b1; in_vec = v; elem_half = half; scan_rev = rev; lsb_mode = ones;
        @(negedge clk);
        in_valid = 1'b0; in_vec = ~v;
        chk(out_valid == 1'b1, req, "out_valid", VW'(out_valid), VW'(1));
        chk(out_vec == er, req, "out_vec", out_vec, er);
        chk(any_zero == eh, req, "any_zero", VW'(any_zero), VW'(eh));
        chk(lsb_test == el, req, "lsb_test", VW'(lsb_test), VW'(el));
        @(negedge clk);
        chk(out_valid == 1'b0, req, "strobe one cycle", VW'(out_valid), VW'(0));
        chk(out_vec == er, "R10", "hold", out_vec, er);
    endtask

    localparam logic [VW-1:0] PAT = 128'h11223344_55667788_99AABBCC_DDEEFF13;

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid", VW'(out_valid), '0);
        chk(out_vec == '0, "R1", "out_vec", out_vec, '0);
        chk(any_zero == 1'b0 && lsb_test == 1'b0, "R1", "flags",
            VW'({any_zero, lsb_test}), '0);
    endtask

    task automatic t_natural();
        logic [VW-1:0] v = PAT;
        v[87:80] = 8'h00;
        apply("R3", v, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reverse();
        logic [VW-1:0] v = PAT;
        v[47:40] = 8'h00;
        v[95:88] = 8'h00;
        apply("R4", v, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_width();
        logic [VW-1:0] v = PAT;
        v[71:64] = 8'h00;                 // zero byte, nonzero halfword
        apply("R5", v, 1'b1, 1'b0, 1'b0);
        apply("R5", v, 1'b0, 1'b0, 1'b0);
        v[79:64] = 16'h0000;
        apply("R5", v, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_no_zero();
        apply("R6", PAT, 1'b0, 1'b0, 1'b0);
        apply("R7", PAT, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_lsb();
        apply("R8", {16{8'h01}}, 1'b0, 1'b0, 1'b1);
        apply("R8", {16{8'h01}}, 1'b1, 1'b1, 1'b0);
        apply("R8", {16{8'hFE}}, 1'b0, 1'b1, 1'b0);
        apply("R8", {{15{8'hFE}}, 8'h03}, 1'b1, 1'b0, 1'b0);
        apply("R8", {{15{8'h03}}, 8'h02}, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_edges();
        logic [VW-1:0] v = PAT;
        v[127:120] = 8'h00;
        apply("R9", v, 1'b0, 1'b0, 1'b0);   // first scanned -> all zero
        apply("R9", v, 1'b0, 1'b1, 1'b0);   // last scanned -> unchanged
        v = PAT; v[15:0] = 16'h0000;
        apply("R9", v, 1'b1, 1'b1, 1'b0);
        apply("R9", v, 1'b1, 1'b0, 1'b0);
        apply("R7", '0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back();
        logic [VW-1:0] a = PAT, b = PAT;
        logic [VW-1:0] ea, eb;
        bit ha, la, hb, lb;
        a[55:48] = 8'h00;
        b[31:16] = 16'h0000;
        expect_of(a, 1'b0, 1'b1, 1'b0, ea, ha, la);
        expect_of(b, 1'b1, 1'b0, 1'b1, eb, hb, lb);
        @(negedge clk);
        in_valid = 1'b1; in_vec = a; elem_half = 1'b0; scan_rev = 1'b1; lsb_mode = 1'b0;
        @(negedge clk);
        chk(out_valid && out_vec == ea, "R2", "first of pair", out_vec, ea);
        in_vec = b; elem_half = 1'b1; scan_rev = 1'b0; lsb_mode = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_vec == eb, "R2", "second of pair", out_vec, eb);
        chk(any_zero == hb, "R2", "second flag", VW'(any_zero), VW'(hb));
        @(negedge clk);
        chk(!out_valid, "R2", "idle after pair", VW'(out_valid), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_natural();
        t_reverse();
        t_width();
        t_no_zero();
        t_lsb();
        t_edges();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule